// File: doc/BRIEF.md
# Programmable Display Raster Timing Generator

This block scans a parallel display raster from a set of runtime-programmable timing values. It produces horizontal sync, vertical sync, a data-enable strobe and the pixel column and row inside the visible area, one pixel per clock. The horizontal values are counted in pixel clocks. The vertical values are counted in lines. Every line and every frame is built from four regions in a fixed order, and any porch or sync region may be set to zero length.

Each of the three control outputs has its own polarity code, which can also switch that output off. Horizontal and vertical sync can be launched on the falling clock edge instead of the rising edge used for pixel data. This suits sinks that sample sync on the opposite edge from data. Timing values are copied into shadow registers only at a frame boundary, or while the block is disabled, so a frame is never torn by a mid-scan reprogram.

Top module: `disp_timing_gen`

## Requirements
- R1: Each line is `h_bp` back-porch pixels, then `h_active` active pixels, then `h_fp` front-porch pixels, then `h_sync_len` sync pixels. `hsync` is at its asserted level exactly during the sync pixels. The line then restarts at back porch.
- R2: Each frame is `v_bp` back-porch lines, then `v_active` active lines, then `v_fp` front-porch lines, then `v_sync_len` sync lines. `vsync` is at its asserted level for every pixel of the sync lines.
- R3: `de` is asserted only when both the horizontal and the vertical position lie in their active regions. `px_x` is the 0-based pixel offset within the horizontal active region and 0 elsewhere. `px_y` is the 0-based line offset within the vertical active region and 0 elsewhere.
- R4: Polarity code `2'b01` makes an output active high and `2'b00` makes it active low. Codes `2'b10` and `2'b11` disable the output and hold it at 0.
- R5: With `sync_fall`=1, `hsync` and `vsync` change on the falling clock edge, half a cycle after the value they would show with `sync_fall`=0. `de`, `px_x` and `px_y` always change on the rising edge.
- R6: A porch or sync value of 0 removes that region from the line or frame, and the following region starts at once.
- R7: Timing values written during a frame take effect from the first pixel of the next frame. The current frame keeps the old values.
- R8: While `en`=0, the scan position is held at pixel 0 of line 0, every control output sits at its inactive level, and `px_x`/`px_y` are 0. The clock after `en` rises outputs pixel 0 of line 0.
- R9: During reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Scan enable |
| h_bp | input | 12 | Horizontal back porch, pixels |
| h_active | input | 12 | Visible pixels per line |
| h_fp | input | 12 | Horizontal front porch, pixels |
| h_sync_len | input | 12 | Horizontal sync length, pixels |
| v_bp | input | 12 | Vertical back porch, lines |
| v_active | input | 12 | Visible lines per frame |
| v_fp | input | 12 | Vertical front porch, lines |
| v_sync_len | input | 12 | Vertical sync length, lines |
| hs_pol | input | 2 | hsync polarity code |
| vs_pol | input | 2 | vsync polarity code |
| de_pol | input | 2 | de polarity code |
| sync_fall | input | 1 | Launch syncs on the falling edge |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| px_x | output | 12 | Active pixel column |
| px_y | output | 12 | Active line row |

## Verification
A corrupted horizontal position shows within one line as a shifted or stretched `hsync` pulse, and as a `px_x` sequence that skips or repeats. A corrupted vertical position or shadow copy shows within one frame as a misplaced `vsync` band, or as `de` appearing on the wrong lines. The bench compares every output on every cycle against an arithmetic model. A fault therefore surfaces on the first pixel where a region boundary is wrong, and a wrong launch edge surfaces one half cycle early on the first sync transition.

// File: rtl/dtg_pkg.sv
`timescale 1ns/1ps
package dtg_pkg;

  typedef enum logic [1:0] {
    RGN_BACK   = 2'd0,
    RGN_ACTIVE = 2'd1,
    RGN_FRONT  = 2'd2,
    RGN_SYNC   = 2'd3
  } region_e;

  localparam logic [1:0] POL_LOW  = 2'b00;
  localparam logic [1:0] POL_HIGH = 2'b01;

  typedef struct packed {
    logic [11:0] bp;
    logic [11:0] act;
    logic [11:0] fp;
    logic [11:0] sy;
  } axis_cfg_t;

  // pol[1] set: output disabled, held at 0
  function automatic logic drive_level(input logic [1:0] pol, input logic asserted);
    if (pol[1])      return 1'b0;
    else if (pol[0]) return asserted;
    else             return ~asserted;
  endfunction

endpackage

// File: rtl/dtg_axis.sv
`timescale 1ns/1ps
module dtg_axis #(
  parameter int W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hold,
  input  logic                step,
  input  dtg_pkg::axis_cfg_t  cfg,
  output dtg_pkg::region_e    region,
  output logic [W-1:0]        coord,
  output logic                last
);
  import dtg_pkg::*;

  localparam int SW = W + 2;

  logic [SW-1:0] b_act, b_fp, b_sy, total;
  logic [SW-1:0] pos_q, pos_d;

  always_comb begin
    b_act = SW'(cfg.bp);
    b_fp  = b_act + SW'(cfg.act);
    b_sy  = b_fp + SW'(cfg.fp);
    total = b_sy + SW'(cfg.sy);
  end

  always_comb begin
    last = (total == '0) || (pos_q >= total - SW'(1));
    if      (pos_q < b_act) region = RGN_BACK;
    else if (pos_q < b_fp)  region = RGN_ACTIVE;
    else if (pos_q < b_sy)  region = RGN_FRONT;
    else                    region = RGN_SYNC;
    coord = (region == RGN_ACTIVE) ? W'(pos_q - b_act) : '0;
  end

  always_comb begin
    pos_d = pos_q;
    if (hold)      pos_d = '0;
    else if (step) pos_d = last ? '0 : pos_q + SW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  p_pos_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q == '0) || (pos_q < total));

  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !hold && last) |=> (pos_q == '0));

endmodule

// File: rtl/dtg_out_pin.sv
`timescale 1ns/1ps
module dtg_out_pin #(
  parameter bit HAS_FALL = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       act,
  input  logic [1:0] pol,
  input  logic       fall_sel,
  output logic       pin
);
  import dtg_pkg::*;

  logic rise_d, rise_q, fall_q;

  always_comb rise_d = drive_level(pol, en & act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rise_q <= 1'b0;
    else        rise_q <= rise_d;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= 1'b0;
    else        fall_q <= rise_q;
  end

  assign pin = (HAS_FALL && fall_sel) ? fall_q : rise_q;

  p_off_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pol[1] |=> !rise_q);

  p_fall_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fall_q == rise_q);

endmodule

// File: rtl/disp_timing_gen.sv
`timescale 1ns/1ps
module disp_timing_gen #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] h_bp,
  input  logic [W-1:0] h_active,
  input  logic [W-1:0] h_fp,
  input  logic [W-1:0] h_sync_len,
  input  logic [W-1:0] v_bp,
  input  logic [W-1:0] v_active,
  input  logic [W-1:0] v_fp,
  input  logic [W-1:0] v_sync_len,
  input  logic [1:0]   hs_pol,
  input  logic [1:0]   vs_pol,
  input  logic [1:0]   de_pol,
  input  logic         sync_fall,
  output logic         hsync,
  output logic         vsync,
  output logic         de,
  output logic [W-1:0] px_x,
  output logic [W-1:0] px_y
);
  import dtg_pkg::*;

  localparam int NPIN = 3;

  axis_cfg_t h_cfg_q, h_cfg_d, v_cfg_q, v_cfg_d;
  region_e   h_rgn, v_rgn;
  logic [W-1:0] h_coord, v_coord;
  logic      h_last, v_last, frame_end, load;
  logic [W-1:0] x_q, x_d, y_q, y_d;

  // shadow copies follow the inputs only at a frame boundary or while idle
  always_comb begin
    frame_end = en && h_last && v_last;
    load      = !en || frame_end;
    h_cfg_d   = h_cfg_q;
    v_cfg_d   = v_cfg_q;
    if (load) begin
      h_cfg_d = '{bp: h_bp, act: h_active, fp: h_fp, sy: h_sync_len};
      v_cfg_d = '{bp: v_bp, act: v_active, fp: v_fp, sy: v_sync_len};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_cfg_q <= '0;
      v_cfg_q <= '0;
    end else begin
      h_cfg_q <= h_cfg_d;
      v_cfg_q <= v_cfg_d;
    end
  end

  dtg_axis #(.W(W)) i_h_axis (
    .clk(clk), .rst_n(rst_n), .hold(!en), .step(1'b1), .cfg(h_cfg_q),
    .region(h_rgn), .coord(h_coord), .last(h_last)
  );

  dtg_axis #(.W(W)) i_v_axis (
    .clk(clk), .rst_n(rst_n), .hold(!en), .step(h_last), .cfg(v_cfg_q),
    .region(v_rgn), .coord(v_coord), .last(v_last)
  );

  logic [NPIN-1:0] pin_act, pin_out, pin_fall;
  logic [1:0]      pin_pol [NPIN];

  always_comb begin
    pin_act[0] = (h_rgn == RGN_SYNC);
    pin_act[1] = (v_rgn == RGN_SYNC);
    pin_act[2] = (h_rgn == RGN_ACTIVE) && (v_rgn == RGN_ACTIVE);
    pin_pol[0] = hs_pol;
    pin_pol[1] = vs_pol;
    pin_pol[2] = de_pol;
    pin_fall   = {1'b0, sync_fall, sync_fall};
  end

  // index 0/1: syncs with falling-edge option, index 2: data enable
  for (genvar gi = 0; gi < NPIN; gi++) begin : g_pin
    dtg_out_pin #(.HAS_FALL(gi < 2)) i_pin (
      .clk(clk), .rst_n(rst_n), .en(en), .act(pin_act[gi]),
      .pol(pin_pol[gi]), .fall_sel(pin_fall[gi]), .pin(pin_out[gi])
    );
  end

  always_comb begin
    x_d = en ? h_coord : '0;
    y_d = en ? v_coord : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else begin
      x_q <= x_d;
      y_q <= y_d;
    end
  end

  assign hsync = pin_out[0];
  assign vsync = pin_out[1];
  assign de    = pin_out[2];
  assign px_x  = x_q;
  assign px_y  = y_q;

  p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !frame_end) |=> ($stable(h_cfg_q) && $stable(v_cfg_q)));

  p_de_both_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((h_rgn != RGN_ACTIVE || v_rgn != RGN_ACTIVE) && de_pol == POL_HIGH) |=> !de);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (px_x == '0 && px_y == '0));

endmodule

// File: tb/test_disp_timing_gen.sv
`timescale 1ns/1ps
module test_disp_timing_gen;

  logic clk = 1'b0;
  logic rst_n, en, sync_fall;
  logic [11:0] cfg [8];
  logic [1:0] hs_pol, vs_pol, de_pol;
  logic hsync, vsync, de;
  logic [11:0] px_x, px_y;

  int nt = 0, nf = 0;
  int mh = 0, mv = 0;
  int sh [8];
  int prev_hs = 0, prev_vs = 0;
  bit done = 0;

  always #2 clk = ~clk;

  disp_timing_gen i_disp_timing_gen (
    .clk(clk), .rst_n(rst_n), .en(en),
    .h_bp(cfg[0]), .h_active(cfg[1]), .h_fp(cfg[2]), .h_sync_len(cfg[3]),
    .v_bp(cfg[4]), .v_active(cfg[5]), .v_fp(cfg[6]), .v_sync_len(cfg[7]),
    .hs_pol(hs_pol), .vs_pol(vs_pol), .de_pol(de_pol), .sync_fall(sync_fall),
    .hsync(hsync), .vsync(vsync), .de(de), .px_x(px_x), .px_y(px_y)
  );

  task automatic chk(string tag, string what, int got, int exp);
    nt++;
    if (got != exp) begin
      nf++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  function automatic int lv(logic [1:0] pol, int a);
    if (pol[1]) return 0;
    if (pol[0]) return a;
    return (a != 0) ? 0 : 1;
  endfunction

  // region: 0 back, 1 active, 2 front, 3 sync
  function automatic int rg(int p, int b, int a, int f);
    if (p < b) return 0;
    if (p < b + a) return 1;
    if (p < b + a + f) return 2;
    return 3;
  endfunction

  task automatic setcfg(int a0, int a1, int a2, int a3, int a4, int a5, int a6, int a7);
    cfg[0] = 12'(a0); cfg[1] = 12'(a1); cfg[2] = 12'(a2); cfg[3] = 12'(a3);
    cfg[4] = 12'(a4); cfg[5] = 12'(a5); cfg[6] = 12'(a6); cfg[7] = 12'(a7);
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) begin
      int hr, vr, ehs, evs, ede, ex, ey, htot, vtot;
      @(posedge clk); #1;
      hr = rg(mh, sh[0], sh[1], sh[2]);
      vr = rg(mv, sh[4], sh[5], sh[6]);
      ehs = lv(hs_pol, (en && hr == 3) ? 1 : 0);
      evs = lv(vs_pol, (en && vr == 3) ? 1 : 0);
      ede = lv(de_pol, (en && hr == 1 && vr == 1) ? 1 : 0);
      ex  = (en && hr == 1) ? mh - sh[0] : 0;
      ey  = (en && vr == 1) ? mv - sh[4] : 0;
      chk(tag, "R1 hsync", int'(hsync), sync_fall ? prev_hs : ehs);
      chk(tag, "R2 vsync", int'(vsync), sync_fall ? prev_vs : evs);
      chk(tag, "R3 de", int'(de), ede);
      chk(tag, "R3 px_x", int'(px_x), ex);
      chk(tag, "R3 px_y", int'(px_y), ey);
      prev_hs = ehs;
      prev_vs = evs;
      if (!en) begin
        mh = 0; mv = 0;
        for (int k = 0; k < 8; k++) sh[k] = int'(cfg[k]);
      end else begin
        htot = sh[0] + sh[1] + sh[2] + sh[3];
        vtot = sh[4] + sh[5] + sh[6] + sh[7];
        if (htot == 0 || mh >= htot - 1) begin
          mh = 0;
          if (vtot == 0 || mv >= vtot - 1) begin
            mv = 0;
            for (int k = 0; k < 8; k++) sh[k] = int'(cfg[k]);
          end else mv++;
        end else mh++;
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; sync_fall = 1'b0;
    hs_pol = 2'b00; vs_pol = 2'b00; de_pol = 2'b01;
    setcfg(1, 4, 2, 3, 2, 3, 1, 1);
    for (int k = 0; k < 8; k++) sh[k] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset", "hsync", int'(hsync), 0);
    chk("R9 reset", "vsync", int'(vsync), 0);
    chk("R9 reset", "de", int'(de), 0);
    chk("R9 reset", "px_x", int'(px_x), 0);
    chk("R9 reset", "px_y", int'(px_y), 0);
    @(negedge clk) rst_n = 1'b1;
    run(4, "R8 idle");
    @(negedge clk) begin hs_pol = 2'b01; vs_pol = 2'b01; en = 1'b1; end
    run(150, "R1/R2/R3 base");
    @(negedge clk) begin hs_pol = 2'b00; vs_pol = 2'b10; de_pol = 2'b00; end
    run(80, "R4 mixed polarity");
    @(negedge clk) begin de_pol = 2'b11; vs_pol = 2'b00; end
    run(40, "R4 disabled de");
    @(negedge clk) begin hs_pol = 2'b01; vs_pol = 2'b01; de_pol = 2'b01; sync_fall = 1'b1; end
    run(150, "R5 falling sync");
    @(negedge clk) begin sync_fall = 1'b0; setcfg(0, 3, 0, 2, 0, 2, 0, 1); end
    run(250, "R6 zero porches");
    @(negedge clk) setcfg(2, 3, 1, 0, 1, 2, 2, 0);
    run(200, "R6 zero sync");
    @(negedge clk) setcfg(1, 4, 2, 3, 2, 3, 1, 1);
    run(150, "R7 settle");
    run(37, "R7 mid frame");
    @(negedge clk) setcfg(2, 5, 1, 2, 1, 2, 1, 2);
    run(200, "R7 shadow");
    run(20, "R8 pre");
    @(negedge clk) en = 1'b0;
    run(6, "R8 hold");
    @(negedge clk) begin en = 1'b1; sync_fall = 1'b1; end
    run(100, "R8 restart");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nt, nf);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      nt++; nf++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nt, nf);
      $finish;
    end
  end

endmodule